// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Static RAM Model

This block is a synthesizable, reduced-depth behavioural model of a quad-data-rate static RAM. It has a read data port and a write data port that work independently, and one address bus that both ports share. A single clock runs at twice the cycle rate. An internal phase toggle labels each rising edge as either the "K" half or the "K#" half of a memory cycle. The phase flag leaves the block as `k_next` so that the driving logic can line up with it. Every access moves two words: the lower word of an 18-bit pair, then the upper word.

The read address is taken in the K half. The write address is taken in the K# half of the same cycle. Within one cycle the address bus therefore carries the read address first and the write address second. Write data arrives one word per half-cycle, each word with its own pair of active-low byte enables. Both words are committed to the array together. Read data leaves on an 18-bit bus with a valid flag, which stands in for a three-state driver. The data bus reads zero whenever the flag is low.

Top module: `qdr_burst_sram`

## Requirements
- R1: A read starts when `rd_sel_n` is low at a K edge, which is an edge where `k_next` was 1 just before it. The read address is taken from `addr` at that same K edge.
- R2: A write starts when `wr_sel_n` is low at a K edge. The write address is taken from `addr` at the K# edge that follows. The value on `addr` at the K edge has no effect on where the write lands.
- R3: The write word taken at the K edge becomes the lower word (returned first). The word taken at the following K# edge becomes the upper word. Both words land in the array together.
- R4: `bw_n` is active low and is sampled separately for each of the two write beats. `bw_n[0]` enables data bits 8:0 and `bw_n[1]` enables bits 17:9.
- R5: A byte whose enable is high during its beat keeps its stored value. A write with all four enables high leaves the location unchanged.
- R6: For a read started at K edge number n, the lower word is on `rdata` with `rvalid` high in the half-cycle after edge n+2. The upper word follows in the half-cycle after edge n+3.
- R7: `rvalid` is high for exactly two consecutive half-cycles per read. Back-to-back reads keep it high without a gap. After the read port is deselected, the pending burst finishes and then `rvalid` falls. `rdata` is zero whenever `rvalid` is low.
- R8: A read and a write can both start at the same K edge, and both complete.
- R9: A read that starts in the same cycle as a write to the same address returns the old contents. A read started in the next cycle returns the new contents.
- R10: During reset and right after it, `rvalid` is 0, `rdata` is 0 and `k_next` is 1.
- R11: `k_next` alternates on every clock edge once reset ends.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its rising edges alternate between the K and K# halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read port select, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write port select, sampled on K edges |
| addr | input | AW | Shared address: read address on a K edge, write address on a K# edge |
| wdata | input | 18 | Write data word for the current half-cycle |
| bw_n | input | 2 | Active-low byte enables for the current write beat |
| rdata | output | 18 | Read data word, zero when not valid |
| rvalid | output | 1 | High while `rdata` carries a read beat |
| k_next | output | 1 | High when the next clock edge is a K edge |

## Verification
A scoreboard keeps a shadow array and checks the read port in every half-cycle. It expects either a specific word at a specific edge or an idle, zeroed bus. The following patterns each tell apart different faults:
- A full write followed by a separate read shows whether the lower and upper words come back in the right order and at the right latency.
- A read and a write to the same address in the same cycle, followed by a read of that address in the next cycle, separates old-data from new-data forwarding and shows whether the commit is placed correctly.
- Partial writes with different byte enables on each beat, plus a write with every enable high, catch a swapped lane, a swapped beat or masking that leaks.
- Back-to-back reads, reads with idle gaps, and writes whose K-edge address differs from their K#-edge address show whether the valid flag has gaps and whether the write address comes from the wrong half.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int AW = 8,
  parameter int DW = 18,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] bw_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          k_next
);
  localparam int LW    = DW / BW;
  localparam int NL    = 2 * BW;
  localparam int DEPTH = 1 << AW;

  logic            phase;
  logic            rd_go, wr_go, rd_have, hi_pend, wr_rdy;
  logic [AW-1:0]   rd_a, wr_a;
  logic [DW-1:0]   wlo, whi;
  logic [BW-1:0]   wm_lo, wm_hi;
  logic [2*DW-1:0] rd_word, mem_rd, wfull;
  logic [NL-1:0]   wmask;

  assign k_next = ~phase;
  assign wfull  = {whi, wlo};
  assign wmask  = {wm_hi, wm_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      rd_go   <= 1'b0;
      wr_go   <= 1'b0;
      rd_have <= 1'b0;
      hi_pend <= 1'b0;
      wr_rdy  <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        rd_go   <= ~rd_sel_n;
        wr_go   <= ~wr_sel_n;
        hi_pend <= rd_have;
        rvalid  <= rd_have;
        rdata   <= rd_have ? rd_word[DW-1:0] : '0;
      end else begin
        rd_have <= rd_go;
        wr_rdy  <= wr_go;
        rvalid  <= hi_pend;
        rdata   <= hi_pend ? rd_word[2*DW-1:DW] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!phase) begin
      if (!rd_sel_n) rd_a <= addr;
      if (!wr_sel_n) begin
        wlo   <= wdata;
        wm_lo <= ~bw_n;
      end
    end else begin
      if (rd_go) rd_word <= mem_rd;
      if (wr_go) begin
        wr_a  <= addr;
        whi   <= wdata;
        wm_hi <= ~bw_n;
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (!phase && wr_rdy && wmask[g]) arr[wr_a] <= wfull[g*LW +: LW];
    end
    assign mem_rd[g*LW +: LW] = arr[rd_a];
  end
endmodule

module qdr_burst_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          k_next
);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  assert_burst_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !k_next) |=> rvalid);

  assert_lower_on_k_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> !k_next);

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (k_next && !rd_sel_n) |-> ##3 rvalid ##1 rvalid);

  assert_deselect_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (k_next && rd_sel_n) |-> ##3 !rvalid);

  assert_phase_alt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    k_next |=> !k_next);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n),
  .rdata(rdata), .rvalid(rvalid), .k_next(k_next)
);

// File: tb/qdr_burst_sram_test.sv
module qdr_burst_sram_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [17:0]   wdata = '0;
  logic [1:0]    bw_n = 2'b11;
  logic [17:0]   rdata;
  logic          rvalid, k_next;

  qdr_burst_sram #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .bw_n(bw_n),
    .rdata(rdata), .rvalid(rvalid), .k_next(k_next)
  );

  always #5 clk = ~clk;

  int ntest = 0, nfail = 0, ne = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [35:0] shadow [256];
  int          q_when[$];
  logic [17:0] q_val[$];
  string       q_tag[$];

  always @(posedge clk) if (rst_n) ne <= ne + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every half-cycle is either an expected beat or idle (R7)
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_when.size() > 0 && q_when[0] == ne) begin
        check(rvalid === 1'b1 && rdata === q_val[0], q_tag[0], {13'd0, rvalid, rdata}, {14'd1, q_val[0]});
        void'(q_when.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
      end else begin
        check(rvalid === 1'b0 && rdata === 18'd0, "R7 idle", {13'd0, rvalid, rdata}, 32'd0);
      end
    end
  end

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [17:0] lo, input logic [1:0] blo,
                                         input logic [17:0] hi, input logic [1:0] bhi);
    logic [35:0] r = old;
    if (!blo[0]) r[8:0]   = lo[8:0];
    if (!blo[1]) r[17:9]  = lo[17:9];
    if (!bhi[0]) r[26:18] = hi[8:0];
    if (!bhi[1]) r[35:27] = hi[17:9];
    return r;
  endfunction

  // one memory cycle: K half then K# half
  task automatic kcyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                      input logic [17:0] lo, input logic [1:0] blo, input logic [17:0] hi,
                      input logic [1:0] bhi, input string tag);
    int e0 = ne + 1;
    check(k_next === 1'b1, "R11 phase", {31'd0, k_next}, 32'd1);
    rd_sel_n = !rd; wr_sel_n = !wr;
    addr  = rd ? ra : ~wa;         // R2: K-edge address must not steer a write
    wdata = lo; bw_n = blo;
    if (rd) begin
      q_when.push_back(e0 + 2); q_val.push_back(shadow[ra][17:0]);  q_tag.push_back({tag, " lo"});
      q_when.push_back(e0 + 3); q_val.push_back(shadow[ra][35:18]); q_tag.push_back({tag, " hi"});
    end
    if (wr) shadow[wa] = merge(shadow[wa], lo, blo, hi, bhi);
    @(negedge clk);
    check(k_next === 1'b0, "R11 phase", {31'd0, k_next}, 32'd0);
    addr = wa; wdata = hi; bw_n = bhi; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, "R7");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rvalid === 1'b0 && rdata === 18'd0, "R10 reset out", {13'd0, rvalid, rdata}, 32'd0);
    check(k_next === 1'b1, "R10 reset phase", {31'd0, k_next}, 32'd1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check(k_next === 1'b0, "R11 toggle", {31'd0, k_next}, 32'd0);
    @(negedge clk);

    // R3 R6 R1: full write then separate read
    kcyc(0, '0, 1, 8'd5, 18'h12345, 2'b00, 18'h26789, 2'b00, "R3");
    idle(1);
    kcyc(1, 8'd5, 0, '0, '0, 2'b11, '0, 2'b11, "R6 R1 read");
    idle(2);

    // R9 R8: same address read+write in one cycle, then read again
    kcyc(1, 8'd5, 1, 8'd5, 18'h0ABCD, 2'b00, 18'h3F00F, 2'b00, "R9 old");
    kcyc(1, 8'd5, 0, '0, '0, 2'b11, '0, 2'b11, "R9 new");
    idle(1);

    // R4 R5: per-beat byte enables
    kcyc(0, '0, 1, 8'd9, 18'h11111, 2'b00, 18'h22222, 2'b00, "R4 init");
    kcyc(0, '0, 1, 8'd9, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01, "R4 mask");
    kcyc(1, 8'd9, 0, '0, '0, 2'b11, '0, 2'b11, "R4 lanes");
    kcyc(0, '0, 1, 8'd9, 18'h00000, 2'b01, 18'h00000, 2'b10, "R4 mask2");
    kcyc(1, 8'd9, 0, '0, '0, 2'b11, '0, 2'b11, "R4 lanes2");
    kcyc(0, '0, 1, 8'd9, 18'h15555, 2'b11, 18'h2AAAA, 2'b11, "R5 none");
    kcyc(1, 8'd9, 0, '0, '0, 2'b11, '0, 2'b11, "R5 unchanged");
    idle(2);

    // R7: back-to-back reads, then deselect
    kcyc(1, 8'd5, 0, '0, '0, 2'b11, '0, 2'b11, "R7 b2b a");
    kcyc(1, 8'd9, 0, '0, '0, 2'b11, '0, 2'b11, "R7 b2b b");
    kcyc(1, 8'd5, 0, '0, '0, 2'b11, '0, 2'b11, "R7 b2b c");
    idle(3);

    // R8 R2: concurrent read and write to different addresses
    kcyc(1, 8'd9, 1, 8'd12, 18'h0F0F0, 2'b00, 18'h30303, 2'b00, "R8 rd");
    kcyc(1, 8'd12, 0, '0, '0, 2'b11, '0, 2'b11, "R8 wr");
    idle(1);

    // R2: a sweep of writes, each with a misleading K-edge address
    for (int i = 0; i < 8; i++)
      kcyc(0, '0, 1, 8'(20 + i), 18'(i * 18'h0451 + 7), 2'b00, 18'(18'h3FFFF - i * 18'h0123), 2'b00, "R2");
    for (int i = 7; i >= 0; i--)
      kcyc(1, 8'(20 + i), (i % 2 == 0), 8'd30, 18'(i), 2'b00, 18'(i + 1), 2'b00, "R2 R8 readback");
    kcyc(1, 8'd30, 0, '0, '0, 2'b11, '0, 2'b11, "R2 last");
    idle(4);

    check(q_when.size() == 0, "R6 drained", q_when.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      ntest++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule